// File: doc/BRIEF.md
# Parallel NOR Flash Command Decoder

This block models the write-command state machine of a 16-bit parallel NOR flash. The chip-enable, write-enable and output-enable strobes and the address and data buses are sampled into a system clock. The block tracks bus writes and recognises three unlock-guarded commands: word program, sector erase and block erase. Once a command is accepted it runs an internal busy interval taken from a cycle counter, updates a small on-chip word array, and returns status words on reads until the interval ends.

Each bus write latches its address when the write opens, which is when the later of the two strobes goes low. It latches its data from the last sampled cycle before the write closes, which is when the earlier of the two strobes goes high. The array is indexed by the low `ARRAY_AW` address bits. Sector and block sizes are powers of two set by parameters. The full-size configuration uses 2K-word sectors (`SECTOR_AW=11`) and 32K-word blocks (`BLOCK_AW=15`). The defaults are scaled down to fit the small array.

Top module: `nor_cmd_decoder`

## Requirements
- R1: After reset the decoder is idle and not busy, and every array word reads 16'hFFFF.
- R2: `data_oe_o` is high exactly while the sampled `ce_ni` and `oe_ni` are both low, one clock after the pins change. When not busy, `data_o` is the array word at `addr_i[ARRAY_AW-1:0]`.
- R3: A write opens in the first sampled cycle where `ce_ni` and `we_ni` are both low, and its address is captured there. Later address changes within the same write have no effect.
- R4: A write closes in the first sampled cycle where either strobe is high. Its data is the value on `data_i` in the last sampled cycle where both strobes were low. This holds for writes controlled by the write-enable strobe and for writes controlled by the chip-enable strobe.
- R5: Programming takes four writes: 8'hAA to 15'h5555, then 8'h55 to 15'h2AAA, then 8'hA0 to 15'h5555, then the target word. Unlock addresses are compared on `addr[14:0]` and unlock bytes on `data[7:0]`. The stored word becomes the old word AND the new data.
- R6: Sector erase takes six writes: AA/5555, 55/2AAA, 80/5555, AA/5555, 55/2AAA, then 8'h50 at any address inside the sector. Every word in the aligned 2^SECTOR_AW-word region is set to all ones, and no other word changes.
- R7: Block erase uses the same six-write sequence with 8'h30 in the last write. It sets the aligned 2^BLOCK_AW-word region to all ones.
- R8: A write that does not match the next expected step returns the decoder to idle and leaves the array unchanged. A later correct sequence is accepted from its first write.
- R9: An accepted command keeps the block busy for `PROG_CYCLES` (program) or `ERASE_CYCLES` (erase) clocks. Writes that close while busy are ignored.
- R10: While busy, reads return a status word with all bits zero except two. Bit 7 is the inverse of bit 7 of the programmed data, or 0 during an erase. Bit 6 is 0 on the first read after the command and inverts at the end of each read. Once not busy, reads return array data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ce_ni | input | 1 | Chip enable, active low |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| addr_i | input | ADDR_W | Word address |
| data_i | input | DATA_W | Write data |
| data_o | output | DATA_W | Read data or status word |
| data_oe_o | output | 1 | Output drive enable (high-impedance when low) |

## Verification
The bench moves the address away from its captured value during every write pulse. It also changes the data on the same cycle the closing strobe rises. A decoder that sampled the wrong edge would store data at the moved address, or store the inverted word. The bench runs a complete program sequence while a program is already busy; a decoder that did not ignore writes while busy would change that word. It also sends a sequence broken in its second step, and an erase whose last byte is wrong; a decoder that kept partial progress would act on them. Sector and block erases are checked against words just outside the region, which would expose off-by-one region masks. Every clock is compared against a behavioural model, so a busy interval one cycle too long or too short, or a toggle bit that inverts at the wrong time, shows up as a mismatch.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_UNL1, S_UNL2, S_PROG, S_ERS0, S_ERS1, S_ERS2
  } seq_state_e;

  typedef enum logic [1:0] {OP_NONE, OP_PROG, OP_SECT, OP_BLK} op_e;

  localparam logic [14:0] UNL_ADDR_A = 15'h5555;
  localparam logic [14:0] UNL_ADDR_B = 15'h2AAA;
  localparam logic [7:0]  KEY_A      = 8'hAA;
  localparam logic [7:0]  KEY_B      = 8'h55;
  localparam logic [7:0]  CMD_PROG   = 8'hA0;
  localparam logic [7:0]  CMD_ERASE  = 8'h80;
  localparam logic [7:0]  CMD_SECT   = 8'h50;
  localparam logic [7:0]  CMD_BLK    = 8'h30;
endpackage

// File: rtl/nor_strobe_sampler.sv
module nor_strobe_sampler #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              wr_done_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              rd_act_o,
  output logic              rd_end_o,
  output logic [ADDR_W-1:0] rd_addr_o
);
  logic              ce1_q, we1_q, oe1_q, ce2_q, we2_q, oe2_q;
  logic [ADDR_W-1:0] addr1_q, alat_q;
  logic [DATA_W-1:0] data1_q, data2_q;
  logic              wr_now, wr_prv, rd_now, rd_prv;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce1_q   <= 1'b1;
      we1_q   <= 1'b1;
      oe1_q   <= 1'b1;
      ce2_q   <= 1'b1;
      we2_q   <= 1'b1;
      oe2_q   <= 1'b1;
      addr1_q <= '0;
      data1_q <= '0;
      data2_q <= '0;
    end else begin
      ce1_q   <= ce_ni;
      we1_q   <= we_ni;
      oe1_q   <= oe_ni;
      addr1_q <= addr_i;
      data1_q <= data_i;
      ce2_q   <= ce1_q;
      we2_q   <= we1_q;
      oe2_q   <= oe1_q;
      data2_q <= data1_q;
    end
  end

  assign wr_now = ~ce1_q & ~we1_q;
  assign wr_prv = ~ce2_q & ~we2_q;
  assign rd_now = ~ce1_q & ~oe1_q;
  assign rd_prv = ~ce2_q & ~oe2_q;

  // address taken when the later strobe falls
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               alat_q <= '0;
    else if (wr_now && !wr_prv) alat_q <= addr1_q;
  end

  assign wr_done_o = wr_prv & ~wr_now;
  assign wr_addr_o = alat_q;
  assign wr_data_o = data2_q;
  assign rd_act_o  = rd_now;
  assign rd_end_o  = rd_prv & ~rd_now;
  assign rd_addr_o = addr1_q;
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16,
  parameter int ARRAY_AW = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_done_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   data_i,
  input  logic                busy_i,
  output seq_state_e          state_o,
  output op_e                 op_o,
  output logic [ARRAY_AW-1:0] op_idx_o,
  output logic [DATA_W-1:0]   op_data_o
);
  seq_state_e state_q, state_d;
  logic       unused_bits;

  function automatic logic step_hit(logic [14:0] a, logic [7:0] k);
    return (addr_i[14:0] == a) && (data_i[7:0] == k);
  endfunction

  always_comb begin
    state_d = state_q;
    op_o    = OP_NONE;
    if (wr_done_i && !busy_i) begin
      state_d = S_IDLE;
      unique case (state_q)
        S_IDLE: if (step_hit(UNL_ADDR_A, KEY_A)) state_d = S_UNL1;
        S_UNL1: if (step_hit(UNL_ADDR_B, KEY_B)) state_d = S_UNL2;
        S_UNL2: begin
          if (step_hit(UNL_ADDR_A, CMD_PROG))       state_d = S_PROG;
          else if (step_hit(UNL_ADDR_A, CMD_ERASE)) state_d = S_ERS0;
        end
        S_PROG: op_o = OP_PROG;
        S_ERS0: if (step_hit(UNL_ADDR_A, KEY_A)) state_d = S_ERS1;
        S_ERS1: if (step_hit(UNL_ADDR_B, KEY_B)) state_d = S_ERS2;
        S_ERS2: begin
          if (data_i[7:0] == CMD_SECT)     op_o = OP_SECT;
          else if (data_i[7:0] == CMD_BLK) op_o = OP_BLK;
        end
        default: state_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_IDLE;
    else         state_q <= state_d;
  end

  assign state_o     = state_q;
  assign op_idx_o    = addr_i[ARRAY_AW-1:0];
  assign op_data_o   = data_i;
  assign unused_bits = ^addr_i;
endmodule

// File: rtl/nor_busy_timer.sv
module nor_busy_timer #(
  parameter int PROG_CYCLES  = 2000,
  parameter int ERASE_CYCLES = 4000,
  parameter int CNT_W        = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             erase_i,
  output logic             busy_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= erase_i ? CNT_W'(ERASE_CYCLES - 1) : CNT_W'(PROG_CYCLES - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/nor_word_array.sv
module nor_word_array
  import nor_cmd_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int ARRAY_AW = 8,
  parameter int SECT_AW  = 4,
  parameter int BLOCK_AW = 6
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  op_e                 op_i,
  input  logic [ARRAY_AW-1:0] op_idx_i,
  input  logic [DATA_W-1:0]   op_data_i,
  input  logic [ARRAY_AW-1:0] rd_idx_i,
  output logic [DATA_W-1:0]   rd_data_o
);
  localparam int DEPTH = 1 << ARRAY_AW;

  logic [DATA_W-1:0] mem_q [DEPTH];

  function automatic logic in_region(int unsigned w, int unsigned sh);
    logic [ARRAY_AW-1:0] wi;
    wi = ARRAY_AW'(w);
    return (wi >> sh) == (op_idx_i >> sh);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < DEPTH; w++) mem_q[w] <= '1;
    end else begin
      for (int w = 0; w < DEPTH; w++) begin
        unique case (op_i)
          OP_PROG: if (ARRAY_AW'(w) == op_idx_i) mem_q[w] <= mem_q[w] & op_data_i;
          OP_SECT: if (in_region(w, SECT_AW))    mem_q[w] <= '1;
          OP_BLK:  if (in_region(w, BLOCK_AW))   mem_q[w] <= '1;
          default: ;
        endcase
      end
    end
  end

  assign rd_data_o = mem_q[rd_idx_i];
endmodule

// File: rtl/nor_cmd_decoder.sv
module nor_cmd_decoder
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 16,
  parameter int ARRAY_AW     = 8,
  parameter int SECTOR_AW    = 4,
  parameter int BLOCK_AW     = 6,
  parameter int PROG_CYCLES  = 2000,
  parameter int ERASE_CYCLES = 4000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o
);
  localparam int MAX_CYC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic                wr_done, rd_act, rd_end, busy, tog_q, poll_q, unused_bits;
  logic [ADDR_W-1:0]   wr_addr, rd_addr;
  logic [DATA_W-1:0]   wr_data, op_data, rd_word, status;
  logic [ARRAY_AW-1:0] op_idx;
  logic [CNT_W-1:0]    busy_cnt;
  seq_state_e          seq_state;
  op_e                 op_kind;

  nor_strobe_sampler #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_sampler (
    .clk_i, .rst_ni, .ce_ni, .we_ni, .oe_ni, .addr_i, .data_i,
    .wr_done_o(wr_done), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .rd_act_o(rd_act), .rd_end_o(rd_end), .rd_addr_o(rd_addr)
  );

  nor_cmd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ARRAY_AW(ARRAY_AW)) i_seq (
    .clk_i, .rst_ni, .wr_done_i(wr_done), .addr_i(wr_addr), .data_i(wr_data),
    .busy_i(busy), .state_o(seq_state), .op_o(op_kind),
    .op_idx_o(op_idx), .op_data_o(op_data)
  );

  nor_busy_timer #(
    .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES), .CNT_W(CNT_W)
  ) i_timer (
    .clk_i, .rst_ni, .start_i(op_kind != OP_NONE),
    .erase_i(op_kind == OP_SECT || op_kind == OP_BLK),
    .busy_o(busy), .cnt_o(busy_cnt)
  );

  nor_word_array #(
    .DATA_W(DATA_W), .ARRAY_AW(ARRAY_AW), .SECT_AW(SECTOR_AW), .BLOCK_AW(BLOCK_AW)
  ) i_array (
    .clk_i, .rst_ni, .op_i(op_kind), .op_idx_i(op_idx), .op_data_i(op_data),
    .rd_idx_i(rd_addr[ARRAY_AW-1:0]), .rd_data_o(rd_word)
  );

  // polling bit and toggle bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tog_q  <= 1'b0;
      poll_q <= 1'b0;
    end else if (op_kind != OP_NONE) begin
      tog_q  <= 1'b0;
      poll_q <= (op_kind == OP_PROG) ? ~op_data[7] : 1'b0;
    end else if (busy && rd_end) begin
      tog_q  <= ~tog_q;
    end
  end

  always_comb begin
    status    = '0;
    status[7] = poll_q;
    status[6] = tog_q;
  end

  assign data_o      = busy ? status : rd_word;
  assign data_oe_o   = rd_act;
  assign unused_bits = ^rd_addr;
endmodule

// File: rtl/nor_cmd_chk.sv
module nor_cmd_chk
  import nor_cmd_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_i,
  input logic [CNT_W-1:0]  cnt_i,
  input seq_state_e        state_i,
  input op_e               op_i,
  input logic              rd_end_i,
  input logic              tog_i,
  input logic              data_oe_i,
  input logic [DATA_W-1:0] data_i
);
  // R9
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && cnt_i != '0 |=> busy_i);

  // R9
  busy_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> $past(cnt_i) == '0);

  // R8
  busy_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> state_i == S_IDLE);

  // R9
  busy_no_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> op_i == OP_NONE);

  // R5
  op_starts_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i != OP_NONE |=> busy_i);

  // R10
  status_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && data_oe_i |-> data_i[DATA_W-1:8] == '0 && data_i[5:0] == '0);

  // R10
  tog_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && rd_end_i |=> tog_i != $past(tog_i));
endmodule

bind nor_cmd_decoder nor_cmd_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_chk (
  .clk_i, .rst_ni, .busy_i(busy), .cnt_i(busy_cnt), .state_i(seq_state),
  .op_i(op_kind), .rd_end_i(rd_end), .tog_i(tog_q), .data_oe_i(data_oe_o),
  .data_i(data_o)
);

// File: tb/test_nor_cmd_decoder.sv
`timescale 1ns/1ps
module test_nor_cmd_decoder;
  localparam int AW = 16, DW = 16, ARR_AW = 8, S_AW = 4, B_AW = 6;
  localparam int P_CYC = 60, E_CYC = 150;

  logic clk = 1'b0, rst_n = 1'b0, ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0, dout;
  logic doe;
  int checks = 0, errors = 0;
  string cur_req = "R1";
  bit done = 0;

  always #2.5 clk = ~clk;

  nor_cmd_decoder #(
    .ADDR_W(AW), .DATA_W(DW), .ARRAY_AW(ARR_AW), .SECTOR_AW(S_AW), .BLOCK_AW(B_AW),
    .PROG_CYCLES(P_CYC), .ERASE_CYCLES(E_CYC)
  ) i_nor_cmd_decoder (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .we_ni(we_n), .oe_ni(oe_n),
    .addr_i(addr), .data_i(din), .data_o(dout), .data_oe_o(doe)
  );

  // behavioural reference model
  int m_mem [1 << ARR_AW];
  bit s1_ce = 1, s1_we = 1, s1_oe = 1, s2_ce = 1, s2_we = 1, s2_oe = 1;
  logic [AW-1:0] s1_addr = '0, m_alat = '0;
  logic [DW-1:0] s1_data = '0, s2_data = '0;
  int m_step = 0, m_cnt = 0;
  bit m_busy = 0, m_tog = 0, m_poll = 0;

  function automatic void m_start(int cyc, bit poll);
    m_busy = 1; m_cnt = cyc - 1; m_tog = 0; m_poll = poll;
  endfunction

  function automatic void m_write(logic [AW-1:0] a, logic [DW-1:0] d);
    bit ka, kb;
    int base, span;
    ka = (a[14:0] == 15'h5555);
    kb = (a[14:0] == 15'h2AAA);
    case (m_step)
      0: m_step = (ka && d[7:0] == 8'hAA) ? 1 : 0;
      1: m_step = (kb && d[7:0] == 8'h55) ? 2 : 0;
      2: m_step = (ka && d[7:0] == 8'hA0) ? 3 : (ka && d[7:0] == 8'h80) ? 4 : 0;
      3: begin
        m_mem[a[ARR_AW-1:0]] = m_mem[a[ARR_AW-1:0]] & int'(d);
        m_start(P_CYC, ~d[7]);
        m_step = 0;
      end
      4: m_step = (ka && d[7:0] == 8'hAA) ? 5 : 0;
      5: m_step = (kb && d[7:0] == 8'h55) ? 6 : 0;
      6: begin
        if (d[7:0] == 8'h50 || d[7:0] == 8'h30) begin
          span = (d[7:0] == 8'h50) ? (1 << S_AW) : (1 << B_AW);
          base = (int'(a[ARR_AW-1:0]) / span) * span;
          for (int i = 0; i < span; i++) m_mem[base + i] = 32'hFFFF;
          m_start(E_CYC, 1'b0);
        end
        m_step = 0;
      end
      default: m_step = 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < (1 << ARR_AW); i++) m_mem[i] = 32'hFFFF;
      s1_ce = 1; s1_we = 1; s1_oe = 1; s2_ce = 1; s2_we = 1; s2_oe = 1;
      s1_addr = '0; s1_data = '0; s2_data = '0; m_alat = '0;
      m_step = 0; m_cnt = 0; m_busy = 0; m_tog = 0; m_poll = 0;
    end else begin
      bit wr_now, wr_prv, rd_now, rd_prv, was_busy;
      wr_now = !s1_ce && !s1_we; wr_prv = !s2_ce && !s2_we;
      rd_now = !s1_ce && !s1_oe; rd_prv = !s2_ce && !s2_oe;
      was_busy = m_busy;
      if (m_busy) begin
        if (m_cnt == 0) m_busy = 0;
        else m_cnt--;
      end
      if (was_busy && rd_prv && !rd_now) m_tog = !m_tog;
      if (!was_busy && wr_prv && !wr_now) m_write(m_alat, s2_data);
      if (wr_now && !wr_prv) m_alat = s1_addr;
      s2_ce = s1_ce; s2_we = s1_we; s2_oe = s1_oe; s2_data = s1_data;
      s1_ce = ce_n; s1_we = we_n; s1_oe = oe_n; s1_addr = addr; s1_data = din;
    end
  end

  // per-cycle comparison against the model (R2, R9, R10)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [DW-1:0] exp_d;
      bit exp_oe;
      exp_oe = !s1_ce && !s1_oe;
      exp_d  = m_busy ? DW'({m_poll, m_tog, 6'b0}) : DW'(m_mem[s1_addr[ARR_AW-1:0]]);
      checks++;
      if (doe !== exp_oe || (exp_oe && dout !== exp_d)) begin
        errors++;
        $display("FAIL %s cycle compare: oe=%b data=%h expected oe=%b data=%h",
                 cur_req, doe, dout, exp_oe, exp_d);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // address moves inside the pulse (R3), data flips as the write closes (R4)
  task automatic bus_write(logic [AW-1:0] a, logic [DW-1:0] d, bit ce_ctrl);
    addr = a; din = d;
    if (ce_ctrl) begin we_n = 0; tick(1); ce_n = 0; end
    else begin ce_n = 0; tick(1); we_n = 0; end
    tick(1);
    addr = ~a;
    tick(1);
    if (ce_ctrl) ce_n = 1; else we_n = 1;
    din = ~d;
    tick(1);
    if (ce_ctrl) we_n = 1; else ce_n = 1;
    tick(1);
  endtask

  task automatic bus_read(logic [AW-1:0] a, output logic [DW-1:0] d);
    addr = a; ce_n = 0; oe_n = 0;
    tick(2);
    d = dout;
    oe_n = 1; ce_n = 1;
    tick(1);
  endtask

  task automatic program_word(logic [AW-1:0] a, logic [DW-1:0] d, bit ce_ctrl);
    bus_write(16'h5555, 16'h00AA, ce_ctrl);
    bus_write(16'h2AAA, 16'h0055, ce_ctrl);
    bus_write(16'h5555, 16'h00A0, ce_ctrl);
    bus_write(a, d, ce_ctrl);
  endtask

  task automatic erase_cmd(logic [AW-1:0] a, logic [7:0] cmd);
    bus_write(16'h5555, 16'h00AA, 0);
    bus_write(16'h2AAA, 16'h0055, 0);
    bus_write(16'h5555, 16'h0080, 0);
    bus_write(16'h5555, 16'h00AA, 0);
    bus_write(16'h2AAA, 16'h0055, 0);
    bus_write(a, {8'h00, cmd}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired: actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] r;
    tick(3);
    rst_n = 1;
    tick(2);

    cur_req = "R1";
    chk("R2 idle drive", {15'b0, doe}, 16'h0000);
    bus_read(16'h0000, r); chk("R1 reset word 0", r, 16'hFFFF);
    bus_read(16'h00AB, r); chk("R1 reset word AB", r, 16'hFFFF);

    cur_req = "R5";
    program_word(16'h0012, 16'h1234, 0);
    cur_req = "R10";
    bus_read(16'h0012, r); chk("R10 poll first read", r, 16'h0080);
    bus_read(16'h0012, r); chk("R10 toggle second read", r, 16'h00C0);
    tick(P_CYC + 4);
    cur_req = "R5";
    bus_read(16'h0012, r); chk("R5 programmed word", r, 16'h1234);
    bus_read(16'hFFED, r); chk("R3 moved address untouched", r, 16'hFFFF);

    program_word(16'h0012, 16'hFF0F, 0);
    tick(P_CYC + 4);
    bus_read(16'h0012, r); chk("R5 AND into stored word", r, 16'h1204);

    cur_req = "R4";
    program_word(16'h0020, 16'h00A5, 1);
    bus_read(16'h0020, r); chk("R10 poll bit inverted", r, 16'h0000);
    cur_req = "R9";
    program_word(16'h0030, 16'h0000, 0);
    tick(P_CYC + 4);
    bus_read(16'h0020, r); chk("R4 chip-enable controlled data", r, 16'h00A5);
    bus_read(16'h0030, r); chk("R9 write while busy ignored", r, 16'hFFFF);

    cur_req = "R8";
    bus_write(16'h5555, 16'h00AA, 0);
    bus_write(16'h1234, 16'h0055, 0);
    bus_write(16'h5555, 16'h00A0, 0);
    bus_write(16'h0040, 16'h0000, 0);
    bus_read(16'h0040, r); chk("R8 broken sequence no busy", r, 16'hFFFF);
    tick(P_CYC + 4);
    bus_read(16'h0040, r); chk("R8 broken sequence no write", r, 16'hFFFF);
    program_word(16'h0041, 16'h0F0F, 0);
    tick(P_CYC + 4);
    bus_read(16'h0041, r); chk("R8 restart accepted", r, 16'h0F0F);

    cur_req = "R6";
    erase_cmd(16'h0015, 8'h50);
    bus_read(16'h0015, r); chk("R10 erase poll", r, 16'h0000);
    bus_read(16'h0015, r); chk("R10 erase toggle", r, 16'h0040);
    tick(E_CYC + 4);
    bus_read(16'h0012, r); chk("R6 sector word cleared", r, 16'hFFFF);
    bus_read(16'h0020, r); chk("R6 next sector kept", r, 16'h00A5);
    bus_read(16'h0041, r); chk("R6 far word kept", r, 16'h0F0F);

    cur_req = "R7";
    program_word(16'h0050, 16'h0000, 1);
    tick(P_CYC + 4);
    erase_cmd(16'h0077, 8'h30);
    tick(E_CYC + 4);
    bus_read(16'h0050, r); chk("R7 block word cleared", r, 16'hFFFF);
    bus_read(16'h0041, r); chk("R7 block edge cleared", r, 16'hFFFF);
    bus_read(16'h0020, r); chk("R7 other block kept", r, 16'h00A5);

    cur_req = "R8";
    erase_cmd(16'h0020, 8'h10);
    bus_read(16'h0020, r); chk("R8 bad erase byte ignored", r, 16'h00A5);
    tick(4);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule